// File: doc/BRIEF.md
# Host-Side Control and Status Register Block

This block is a byte-wide register file on a host bus. Each access presents a nine-bit address. Three fields in that address choose what happens:

- the low bits pick one of 32 byte slots;
- two bits pick the operation, so that a single bus cycle can overwrite a register, clear bits in it, set bits in it, or read it;
- two high bits pick the area. One area holds the working registers. One is reserved. Two are read-only identification areas: one holds the adapter's 48-bit station address, the other holds fixed test bytes.

Because the operation travels in the address, the host can set or clear individual flags in one cycle, with no read-modify-write window.

The working registers come in even/odd pairs:

- base relocation;
- host-facing interrupt status;
- adapter-facing interrupt status;
- timer control;
- timer value;
- memory paging.

The adapter side of the chip drives set strobes into the host interrupt status pair and sees the request flags the host raises. One interrupt line goes to the host. It is gated by an enable bit held in the even host status register.

A modifying access to a slot or area that holds no writable register leaves every register alone and raises an access-violation flag instead.

Top module: `acr_regfile`

## Requirements
- R1: Address bits [4:0] select the slot, bits [6:5] the operation (00 overwrite, 01 AND with data, 10 OR with data, 11 read), bits [8:7] the area (00 registers, 01 reserved, 10 identification A, 11 identification B). An access takes effect only in a cycle where `host_req` is high.
- R2: A read drives the addressed byte on `host_rdata` with `host_rvalid` high in the cycle after the request. The defined register slots are 0x00, 0x01, 0x08 to 0x0F, 0x18 and 0x19. All other register slots, and the whole reserved area, read as zero.
- R3: Overwrite stores the data byte. AND stores the old value ANDed with the data byte. OR stores the old value ORed with the data byte. Each is visible from the next cycle.
- R4: In identification A, slots 0 to 5 return the bytes of parameter `NODE_ADDR`, most significant byte at slot 0, and other slots return zero. In identification B, even slots return 0xAA and odd slots return 0x55.
- R5: An overwrite, AND or OR aimed at the reserved area, either identification area, or an undefined register slot changes no register and sets bit 2 of slot 0x08.
- R6: `host_irq` is high exactly when bit 6 of slot 0x08 is set and at least one of bits 4..2 of slot 0x08 or bits 6..2 of slot 0x09 is set. With bit 6 clear, `host_irq` stays low.
- R7: `adp_set_hsts_e` bits 4 and 3 are ORed into slot 0x08, and `adp_set_hsts_o` bits 6..2 are ORed into slot 0x09. Their other bits are ignored. When a host access hits the same register in the same cycle, the host result is formed first and the adapter bits are ORed into it.
- R8: `adp_req` always shows slot 0x0B. In that slot, bit 5 means a command is ready, bit 4 means a response is ready, and bits 1 and 0 mark the command and status areas free.
- R9: `page_en` is high when bits 7 and 6 of slot 0x18 are both set, for example after writing 0xC0 to it.
- R10: `reloc_base` shows bits 7..1 of slot 0x00.
- R11: Reset (active low, asynchronous) clears every register, including the interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Host access strobe, one cycle per access |
| host_addr | input | 9 | Slot, operation and area fields |
| host_wdata | input | 8 | Data byte for overwrite, AND and OR |
| host_rdata | output | 8 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read data valid, one cycle after a read |
| adp_set_hsts_e | input | 8 | Adapter set strobes for slot 0x08 |
| adp_set_hsts_o | input | 8 | Adapter set strobes for slot 0x09 |
| adp_req | output | 8 | Host-to-adapter request flags (slot 0x0B) |
| host_irq | output | 1 | Host interrupt |
| page_en | output | 1 | Shared memory paging enabled |
| reloc_base | output | 7 | Relocation base from slot 0x00 |

## Verification
The hardest case to reach from the ports is a host AND or overwrite and an adapter set strobe landing on the same status register in the same cycle. A bug in merge order shows up only then, because otherwise the adapter event is simply overwritten. The bench's access task therefore drives the adapter strobes in the same cycle as the host request. It does this on both host status registers, and it picks data bytes that would clear the very bit the adapter sets. It also aims rejected writes at slots whose old contents are known, so it can tell a true no-op apart from a silent corruption.

// File: rtl/acr_pkg.sv
package acr_pkg;

    localparam int SLOT_W = 5;
    localparam int DATA_W = 8;
    localparam int ADDR_W = SLOT_W + 4;

    typedef enum logic [1:0] {
        OP_WR  = 2'b00,
        OP_AND = 2'b01,
        OP_OR  = 2'b10,
        OP_RD  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        AR_CTRL = 2'b00,
        AR_RSVD = 2'b01,
        AR_IDA  = 2'b10,
        AR_IDB  = 2'b11
    } area_e;

    localparam logic [SLOT_W-1:0] SL_RELOC_E = 5'h00;
    localparam logic [SLOT_W-1:0] SL_RELOC_O = 5'h01;
    localparam logic [SLOT_W-1:0] SL_HSTS_E  = 5'h08;
    localparam logic [SLOT_W-1:0] SL_HSTS_O  = 5'h09;
    localparam logic [SLOT_W-1:0] SL_ASTS_E  = 5'h0A;
    localparam logic [SLOT_W-1:0] SL_ASTS_O  = 5'h0B;
    localparam logic [SLOT_W-1:0] SL_TCTL_E  = 5'h0C;
    localparam logic [SLOT_W-1:0] SL_TCTL_O  = 5'h0D;
    localparam logic [SLOT_W-1:0] SL_TVAL_E  = 5'h0E;
    localparam logic [SLOT_W-1:0] SL_TVAL_O  = 5'h0F;
    localparam logic [SLOT_W-1:0] SL_PAGE_E  = 5'h18;
    localparam logic [SLOT_W-1:0] SL_PAGE_O  = 5'h19;

    localparam int HSTS_IEN_BIT = 6;
    localparam int HSTS_ACC_BIT = 2;
    localparam logic [DATA_W-1:0] HSTS_E_PEND_MASK = 8'h1C;
    localparam logic [DATA_W-1:0] HSTS_O_PEND_MASK = 8'h7C;
    localparam logic [DATA_W-1:0] ADP_E_SET_MASK   = 8'h18;
    localparam logic [DATA_W-1:0] ADP_O_SET_MASK   = 8'h7C;
    localparam logic [DATA_W-1:0] IDB_EVEN_BYTE    = 8'hAA;
    localparam logic [DATA_W-1:0] IDB_ODD_BYTE     = 8'h55;

    typedef struct packed {
        logic [DATA_W-1:0] reloc_e;
        logic [DATA_W-1:0] reloc_o;
        logic [DATA_W-1:0] hsts_e;
        logic [DATA_W-1:0] hsts_o;
        logic [DATA_W-1:0] asts_e;
        logic [DATA_W-1:0] asts_o;
        logic [DATA_W-1:0] tctl_e;
        logic [DATA_W-1:0] tctl_o;
        logic [DATA_W-1:0] tval_e;
        logic [DATA_W-1:0] tval_o;
        logic [DATA_W-1:0] page_e;
        logic [DATA_W-1:0] page_o;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } state_t;

    function automatic logic [DATA_W-1:0] apply_op(
        input logic [DATA_W-1:0] old_v,
        input op_e               op,
        input logic [DATA_W-1:0] wd
    );
        case (op)
            OP_WR:   return wd;
            OP_AND:  return old_v & wd;
            OP_OR:   return old_v | wd;
            default: return old_v;
        endcase
    endfunction

endpackage

// File: rtl/acr_decode.sv
module acr_decode
    import acr_pkg::*;
(
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op,
    output area_e             area,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_defined,
    output logic              rd_hit,
    output logic              wr_hit,
    output logic              wr_bad
);

    logic modify;

    always_comb begin
        slot = addr[SLOT_W-1:0];
        op   = op_e'(addr[SLOT_W+1:SLOT_W]);
        area = area_e'(addr[SLOT_W+3:SLOT_W+2]);

        case (slot)
            SL_RELOC_E, SL_RELOC_O,
            SL_HSTS_E,  SL_HSTS_O,
            SL_ASTS_E,  SL_ASTS_O,
            SL_TCTL_E,  SL_TCTL_O,
            SL_TVAL_E,  SL_TVAL_O,
            SL_PAGE_E,  SL_PAGE_O: slot_defined = 1'b1;
            default:               slot_defined = 1'b0;
        endcase

        modify = req && (op != OP_RD);
        rd_hit = req && (op == OP_RD);
        wr_hit = modify && (area == AR_CTRL) && slot_defined;
        wr_bad = modify && !((area == AR_CTRL) && slot_defined);
    end

endmodule

// File: rtl/acr_idrom.sv
module acr_idrom
    import acr_pkg::*;
#(
    parameter logic [47:0] NODE_ADDR = 48'h10005A3C7E91
) (
    input  area_e             area,
    input  logic [SLOT_W-1:0] slot,
    output logic [DATA_W-1:0] id_byte
);

    localparam int ID_BYTES = 48 / DATA_W;

    logic [DATA_W-1:0] ida_tab [ID_BYTES];

    genvar gi;
    generate
        for (gi = 0; gi < ID_BYTES; gi++) begin : g_ida
            assign ida_tab[gi] = NODE_ADDR[47 - gi*DATA_W -: DATA_W];
        end
    endgenerate

    always_comb begin
        id_byte = '0;
        if (area == AR_IDA) begin
            for (int i = 0; i < ID_BYTES; i++) begin
                if (slot == SLOT_W'(i)) id_byte = ida_tab[i];
            end
        end else if (area == AR_IDB) begin
            id_byte = slot[0] ? IDB_ODD_BYTE : IDB_EVEN_BYTE;
        end
    end

endmodule

// File: rtl/acr_irq.sv
module acr_irq
    import acr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] hsts_e,
    input  logic [DATA_W-1:0] hsts_o,
    output logic              irq
);

    logic pending;

    always_comb begin
        pending = |(hsts_e & HSTS_E_PEND_MASK) || |(hsts_o & HSTS_O_PEND_MASK);
        irq     = hsts_e[HSTS_IEN_BIT] && pending;
    end

    // R6: a cleared enable bit keeps the line low whatever is pending
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !hsts_e[HSTS_IEN_BIT] |-> !irq);

    // R6: a set enable with pending odd-side status raises the line
    p_irq_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (hsts_e[HSTS_IEN_BIT] && |(hsts_o & HSTS_O_PEND_MASK)) |-> irq);

endmodule

// File: rtl/acr_regfile.sv
module acr_regfile
    import acr_pkg::*;
#(
    parameter logic [47:0] NODE_ADDR = 48'h10005A3C7E91
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_req,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic [DATA_W-1:0]    host_wdata,
    output logic [DATA_W-1:0]    host_rdata,
    output logic                 host_rvalid,
    input  logic [DATA_W-1:0]    adp_set_hsts_e,
    input  logic [DATA_W-1:0]    adp_set_hsts_o,
    output logic [DATA_W-1:0]    adp_req,
    output logic                 host_irq,
    output logic                 page_en,
    output logic [DATA_W-2:0]    reloc_base
);

    state_t s_d, s_q;

    op_e               dec_op;
    area_e             dec_area;
    logic [SLOT_W-1:0] dec_slot;
    logic              dec_defined;
    logic              dec_rd;
    logic              dec_wr;
    logic              dec_bad;
    logic [DATA_W-1:0] id_byte;
    logic [DATA_W-1:0] reg_byte;

    acr_decode u_dec (
        .req          (host_req),
        .addr         (host_addr),
        .op           (dec_op),
        .area         (dec_area),
        .slot         (dec_slot),
        .slot_defined (dec_defined),
        .rd_hit       (dec_rd),
        .wr_hit       (dec_wr),
        .wr_bad       (dec_bad)
    );

    acr_idrom #(.NODE_ADDR(NODE_ADDR)) u_id (
        .area    (dec_area),
        .slot    (dec_slot),
        .id_byte (id_byte)
    );

    acr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hsts_e (s_q.hsts_e),
        .hsts_o (s_q.hsts_o),
        .irq    (host_irq)
    );

    always_comb begin
        case (dec_slot)
            SL_RELOC_E: reg_byte = s_q.reloc_e;
            SL_RELOC_O: reg_byte = s_q.reloc_o;
            SL_HSTS_E:  reg_byte = s_q.hsts_e;
            SL_HSTS_O:  reg_byte = s_q.hsts_o;
            SL_ASTS_E:  reg_byte = s_q.asts_e;
            SL_ASTS_O:  reg_byte = s_q.asts_o;
            SL_TCTL_E:  reg_byte = s_q.tctl_e;
            SL_TCTL_O:  reg_byte = s_q.tctl_o;
            SL_TVAL_E:  reg_byte = s_q.tval_e;
            SL_TVAL_O:  reg_byte = s_q.tval_o;
            SL_PAGE_E:  reg_byte = s_q.page_e;
            SL_PAGE_O:  reg_byte = s_q.page_o;
            default:    reg_byte = '0;
        endcase
    end

    always_comb begin
        s_d        = s_q;
        s_d.rvalid = 1'b0;

        if (dec_wr) begin
            case (dec_slot)
                SL_RELOC_E: s_d.reloc_e = apply_op(s_q.reloc_e, dec_op, host_wdata);
                SL_RELOC_O: s_d.reloc_o = apply_op(s_q.reloc_o, dec_op, host_wdata);
                SL_HSTS_E:  s_d.hsts_e  = apply_op(s_q.hsts_e,  dec_op, host_wdata);
                SL_HSTS_O:  s_d.hsts_o  = apply_op(s_q.hsts_o,  dec_op, host_wdata);
                SL_ASTS_E:  s_d.asts_e  = apply_op(s_q.asts_e,  dec_op, host_wdata);
                SL_ASTS_O:  s_d.asts_o  = apply_op(s_q.asts_o,  dec_op, host_wdata);
                SL_TCTL_E:  s_d.tctl_e  = apply_op(s_q.tctl_e,  dec_op, host_wdata);
                SL_TCTL_O:  s_d.tctl_o  = apply_op(s_q.tctl_o,  dec_op, host_wdata);
                SL_TVAL_E:  s_d.tval_e  = apply_op(s_q.tval_e,  dec_op, host_wdata);
                SL_TVAL_O:  s_d.tval_o  = apply_op(s_q.tval_o,  dec_op, host_wdata);
                SL_PAGE_E:  s_d.page_e  = apply_op(s_q.page_e,  dec_op, host_wdata);
                SL_PAGE_O:  s_d.page_o  = apply_op(s_q.page_o,  dec_op, host_wdata);
                default: ;
            endcase
        end

        if (dec_bad) begin
            s_d.hsts_e[HSTS_ACC_BIT] = 1'b1;
        end

        // adapter events land after the host operation so none is lost
        s_d.hsts_e = s_d.hsts_e | (adp_set_hsts_e & ADP_E_SET_MASK);
        s_d.hsts_o = s_d.hsts_o | (adp_set_hsts_o & ADP_O_SET_MASK);

        if (dec_rd) begin
            s_d.rvalid = 1'b1;
            s_d.rdata  = (dec_area == AR_CTRL) ? reg_byte : id_byte;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign host_rdata  = s_q.rdata;
    assign host_rvalid = s_q.rvalid;
    assign adp_req     = s_q.asts_o;
    assign page_en     = &s_q.page_e[DATA_W-1:DATA_W-2];
    assign reloc_base  = s_q.reloc_e[DATA_W-1:1];

    // R5: a rejected modify sets the access flag
    p_bad_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_bad |=> s_q.hsts_e[HSTS_ACC_BIT]);

    // R5: a rejected modify leaves plain storage untouched
    p_bad_no_touch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dec_bad |=> ($stable(s_q.reloc_e) && $stable(s_q.tctl_e)
                     && $stable(s_q.page_e) && $stable(s_q.asts_o)));

    // R7: adapter set strobes on the odd status register are never dropped
    p_adp_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        |(adp_set_hsts_o & ADP_O_SET_MASK) |=>
        ((s_q.hsts_o & $past(adp_set_hsts_o & ADP_O_SET_MASK))
         == $past(adp_set_hsts_o & ADP_O_SET_MASK)));

    // R2: every read produces exactly one valid cycle next
    p_read_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_rd |=> host_rvalid);

    p_no_spurious_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_rd |=> !host_rvalid);

endmodule

// File: tb/tb_acr_regfile.sv
module tb_acr_regfile;
    import acr_pkg::*;

    localparam logic [47:0] NODE = 48'h10005A3C7E91;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 host_req = 1'b0;
    logic [ADDR_W-1:0]    host_addr = '0;
    logic [DATA_W-1:0]    host_wdata = '0;
    logic [DATA_W-1:0]    host_rdata;
    logic                 host_rvalid;
    logic [DATA_W-1:0]    adp_set_hsts_e = '0;
    logic [DATA_W-1:0]    adp_set_hsts_o = '0;
    logic [DATA_W-1:0]    adp_req;
    logic                 host_irq;
    logic                 page_en;
    logic [DATA_W-2:0]    reloc_base;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_q [$];
    string      tag_q [$];

    acr_regfile #(.NODE_ADDR(NODE)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .host_req       (host_req),
        .host_addr      (host_addr),
        .host_wdata     (host_wdata),
        .host_rdata     (host_rdata),
        .host_rvalid    (host_rvalid),
        .adp_set_hsts_e (adp_set_hsts_e),
        .adp_set_hsts_o (adp_set_hsts_o),
        .adp_req        (adp_req),
        .host_irq       (host_irq),
        .page_en        (page_en),
        .reloc_base     (reloc_base)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one access cycle, optionally with adapter strobes in the same cycle
    task automatic acc(input logic [1:0] area, input logic [1:0] op,
                       input logic [4:0] slot, input logic [7:0] d,
                       input logic [7:0] se, input logic [7:0] so);
        @(negedge clk);
        host_req       = 1'b1;
        host_addr      = {area, op, slot};
        host_wdata     = d;
        adp_set_hsts_e = se;
        adp_set_hsts_o = so;
        @(negedge clk);
        host_req       = 1'b0;
        adp_set_hsts_e = '0;
        adp_set_hsts_o = '0;
    endtask

    task automatic wr(input logic [1:0] op, input logic [4:0] slot, input logic [7:0] d);
        acc(2'b00, op, slot, d, 8'h00, 8'h00);
    endtask

    task automatic rd(input logic [1:0] area, input logic [4:0] slot,
                      input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        acc(area, 2'b11, slot, 8'h00, 8'h00, 8'h00);
    endtask

    task automatic adp_pulse(input logic [7:0] se, input logic [7:0] so);
        @(negedge clk);
        adp_set_hsts_e = se;
        adp_set_hsts_o = so;
        @(negedge clk);
        adp_set_hsts_e = '0;
        adp_set_hsts_o = '0;
    endtask

    // monitor: pops the scoreboard whenever a read result appears
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2 unexpected read data actual=%h expected=none", host_rdata);
            end else begin
                chk(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk("R11 irq after reset", {7'b0, host_irq}, 8'h00);
        chk("R11 page_en after reset", {7'b0, page_en}, 8'h00);
        chk("R11 adp_req after reset", adp_req, 8'h00);
        rd(2'b00, 5'h08, 8'h00, "R11 hsts_e after reset");

        // R10 / R2 / R1 overwrite of relocation
        wr(2'b00, 5'h00, 8'hA4);
        chk("R10 reloc_base", {1'b0, reloc_base}, 8'h52);
        rd(2'b00, 5'h00, 8'hA4, "R2 R1 read reloc_e");

        // R3 atomic AND / OR
        wr(2'b00, 5'h0C, 8'hF0);
        wr(2'b01, 5'h0C, 8'h3C);
        rd(2'b00, 5'h0C, 8'h30, "R3 AND result");
        wr(2'b10, 5'h0C, 8'h05);
        rd(2'b00, 5'h0C, 8'h35, "R3 OR result");

        // R4 identification areas, R2 undefined and reserved read zero
        rd(2'b10, 5'h00, 8'h10, "R4 R1 idA slot0");
        rd(2'b10, 5'h05, 8'h91, "R4 idA slot5");
        rd(2'b10, 5'h06, 8'h00, "R4 idA slot6 zero");
        rd(2'b11, 5'h02, 8'hAA, "R4 idB even");
        rd(2'b11, 5'h03, 8'h55, "R4 idB odd");
        rd(2'b01, 5'h0C, 8'h00, "R2 reserved area reads zero");
        rd(2'b00, 5'h10, 8'h00, "R2 undefined slot reads zero");

        // R5 write into identification B aliasing slot 0
        acc(2'b11, 2'b00, 5'h00, 8'hFF, 8'h00, 8'h00);
        chk("R5 reloc unchanged after idB write", {1'b0, reloc_base}, 8'h52);
        rd(2'b00, 5'h08, 8'h04, "R5 access flag set");
        chk("R6 irq low with enable clear", {7'b0, host_irq}, 8'h00);

        // R5 write into reserved area aliasing timer control
        acc(2'b01, 2'b00, 5'h0C, 8'h00, 8'h00, 8'h00);
        rd(2'b00, 5'h0C, 8'h35, "R5 reserved write ignored");

        // R6 enable gating
        wr(2'b10, 5'h08, 8'h40);
        chk("R6 irq with enable and access flag", {7'b0, host_irq}, 8'h01);
        wr(2'b01, 5'h08, 8'hFB);
        chk("R6 irq clears when status cleared", {7'b0, host_irq}, 8'h00);

        // R7 adapter set, masking
        adp_pulse(8'h00, 8'hFF);
        rd(2'b00, 5'h09, 8'h7C, "R7 odd set masked");
        chk("R6 irq from odd status", {7'b0, host_irq}, 8'h01);
        wr(2'b00, 5'h09, 8'h00);
        chk("R6 irq low after odd clear", {7'b0, host_irq}, 8'h00);

        // R7 merge: host overwrite and adapter set same cycle
        acc(2'b00, 2'b00, 5'h09, 8'h00, 8'h00, 8'h20);
        rd(2'b00, 5'h09, 8'h20, "R7 merge odd overwrite");
        chk("R6 irq after merge", {7'b0, host_irq}, 8'h01);
        wr(2'b00, 5'h09, 8'h00);

        // R7 even side set and merge with AND
        adp_pulse(8'hFF, 8'h00);
        rd(2'b00, 5'h08, 8'h58, "R7 even set masked");
        acc(2'b00, 2'b01, 5'h08, 8'hE7, 8'h10, 8'h00);
        rd(2'b00, 5'h08, 8'h50, "R7 merge even AND");
        wr(2'b00, 5'h08, 8'h00);

        // R8 request flags toward adapter
        wr(2'b00, 5'h0B, 8'h31);
        chk("R8 adp_req write", adp_req, 8'h31);
        wr(2'b01, 5'h0B, 8'hDF);
        chk("R8 adp_req AND", adp_req, 8'h11);

        // R9 paging enable
        wr(2'b00, 5'h18, 8'hC0);
        chk("R9 page_en on", {7'b0, page_en}, 8'h01);
        wr(2'b00, 5'h18, 8'h80);
        chk("R9 page_en off", {7'b0, page_en}, 8'h00);

        // R5 undefined control slot
        wr(2'b00, 5'h10, 8'hFF);
        rd(2'b00, 5'h08, 8'h04, "R5 undefined slot write flags access");
        chk("R8 adp_req untouched by bad write", adp_req, 8'h11);

        // R11 reset mid-run
        wr(2'b10, 5'h18, 8'hC0);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R11 page_en cleared", {7'b0, page_en}, 8'h00);
        chk("R11 adp_req cleared", adp_req, 8'h00);
        rst_n = 1'b1;
        rd(2'b00, 5'h0C, 8'h00, "R11 timer control cleared");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_checks++;
            n_fail++;
            $display("FAIL R2 missing reads actual=%0d expected=0", exp_q.size());
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule